// File: doc/BRIEF.md
# Field Memory Write Port Controller

This block drives the write side of a field memory built from a simple dual-port RAM. It runs on the write clock and accepts a field-start reset, a write enable, a store mask and a data word. From these it produces the RAM write address, the write data and a write strobe. The field memory then behaves like a programmable delay line: each field is written from address zero, one word per enabled clock.

Each control and its data word pass through a fixed two-stage pipeline before they act on the address pointer or the RAM. The write enable decides whether the pointer moves. The store mask decides only whether the word lands in the RAM. A masked word still uses up its address, so the geometry of a field does not change when words are dropped. The pointer wraps at the configured depth. The block also flags a field-start reset that arrives too soon after a burst of writing.

Top module: `fieldmem_wr_ctrl`

## Requirements
- R1: A rising clock edge that samples `wr_rst` high sets `mem_addr` to 0. Every control already in the pipeline is discarded, so `mem_we` is low in the cycle after that edge.
- R2: With `wr_en` sampled high at edge E, `mem_addr` increases by one at edge E+2. With `wr_en` sampled low, nothing is stored and the pointer keeps its value at E+2.
- R3: With `wr_en` high and `in_en` low sampled at edge E, `mem_we` stays low for that word, but the pointer still advances at E+2.
- R4: The word on `din` at sampling edge E appears on `mem_data` with `mem_we` high during the cycle between edges E+1 and E+2. The RAM commits it at E+2 to the address that `mem_addr` holds in that cycle.
- R5: The pointer wraps from DEPTH-1 back to 0.
- R6: `wr_rst` takes priority over `wr_en` and `in_en` sampled on the same edge, and over words still in the pipeline. None of those words is stored.
- R7: `proto_err` is set at a reset edge that follows fewer than 3 consecutive edges that sampled `wr_en` low. It is cleared at a reset edge that follows 3 or more such edges, and it keeps its value between reset edges.
- R8: While `rst_n` is low, `mem_addr` is 0, `mem_we` is 0 and `proto_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_rst | input | 1 | Field start: zero the write pointer |
| wr_en | input | 1 | Accept the word and advance the pointer |
| in_en | input | 1 | Store mask: high stores the word, low skips it |
| din | input | DW | Input data word |
| mem_addr | output | AW | RAM write address |
| mem_data | output | DW | RAM write data |
| mem_we | output | 1 | RAM write strobe |
| proto_err | output | 1 | Reset arrived without the required idle lead-in |

## Verification
The hardest case to reach is a field-start reset that lands while two accepted words are still in the pipeline. One of those words has its strobe already on the RAM port in the very cycle of the reset. To reach it, the bench drives two enabled words on consecutive clocks and raises the reset on the next clock, with the enable still high. It then checks that neither prefilled RAM location changed, that the pointer reads zero and that the idle-rule flag is set. The wrap case runs more words than the depth so that the first locations are overwritten.

// File: rtl/fieldmem_wr_ctrl.sv
`timescale 1ns/1ps
module fieldmem_wr_ctrl #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rst,
  input  logic          wr_en,
  input  logic          in_en,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          mem_we,
  output logic          proto_err
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr;
  logic          s1_en, s1_ie, s2_en, s2_ie;
  logic [DW-1:0] s1_d, s2_d;
  logic [1:0]    idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      s1_en     <= 1'b0;
      s1_ie     <= 1'b0;
      s2_en     <= 1'b0;
      s2_ie     <= 1'b0;
      proto_err <= 1'b0;
    end else if (wr_rst) begin
      ptr       <= '0;
      s1_en     <= 1'b0;
      s1_ie     <= 1'b0;
      s2_en     <= 1'b0;
      s2_ie     <= 1'b0;
      proto_err <= (idle_cnt != 2'd3);
    end else begin
      s1_en <= wr_en;
      s1_ie <= in_en;
      s2_en <= s1_en;
      s2_ie <= s1_ie;
      if (s2_en) ptr <= (ptr == LAST) ? '0 : ptr + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    s1_d <= din;
    s2_d <= s1_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               idle_cnt <= 2'd0;
    else if (wr_en)           idle_cnt <= 2'd0;
    else if (idle_cnt != 2'd3) idle_cnt <= idle_cnt + 2'd1;
  end

  assign mem_addr = ptr;
  assign mem_data = s2_d;
  assign mem_we   = s2_en & s2_ie & ~wr_rst;

  assert_ptr_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> (mem_addr == '0));

  assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> !mem_we);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rst && !s2_en) |=> $stable(ptr));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rst && s2_en && ptr != LAST) |=> (ptr == $past(ptr) + AW'(1)));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rst && s2_en && ptr == LAST) |=> (ptr == '0));

  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rst && idle_cnt != 2'd3) |=> proto_err);

  assert_err_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rst |=> $stable(proto_err));

endmodule

// File: tb/fieldmem_wr_ctrl_tb_top.sv
`timescale 1ns/1ps
module fieldmem_wr_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int AW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_rst = 1'b0, wr_en = 1'b0, in_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic mem_we, proto_err;
  logic [DW-1:0] ram [DEPTH];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fieldmem_wr_ctrl #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_rst(wr_rst), .wr_en(wr_en), .in_en(in_en),
    .din(din), .mem_addr(mem_addr), .mem_data(mem_data), .mem_we(mem_we),
    .proto_err(proto_err));

  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_data;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fill(logic [DW-1:0] v);
    for (int i = 0; i < DEPTH; i++) ram[i] = v;
  endtask

  task automatic field_start();
    wr_en = 0; wr_rst = 0;
    repeat (3) tick();
    wr_rst = 1;
    tick();
    wr_rst = 0;
  endtask

  task automatic drain();
    wr_en = 0;
    repeat (3) tick();
  endtask

  task automatic t_reset_state();
    check("R8 addr", mem_addr, 0);
    check("R8 we", mem_we, 0);
    check("R8 err", proto_err, 0);
  endtask

  task automatic t_latency();
    field_start();
    check("R1 addr after reset", mem_addr, 0);
    check("R7 clean reset", proto_err, 0);
    wr_en = 1; in_en = 1; din = 16'hABCD;
    tick();
    wr_en = 0; din = 16'h0000;
    check("R4 no strobe after E", mem_we, 0);
    tick();
    check("R4 strobe after E+1", mem_we, 1);
    check("R4 data", mem_data, 16'hABCD);
    check("R4 addr", mem_addr, 0);
    tick();
    check("R4 strobe gone", mem_we, 0);
    check("R2 addr step", mem_addr, 1);
    check("R4 ram[0]", ram[0], 16'hABCD);
  endtask

  task automatic t_mask();
    fill(16'hDEAD);
    field_start();
    for (int i = 0; i < 8; i++) begin
      wr_en = 1; in_en = (i % 2 == 0); din = 16'(16'h0200 + i);
      tick();
    end
    drain();
    for (int i = 0; i < 8; i++)
      check("R3 mask", ram[i], (i % 2 == 0) ? 16'h0200 + i : 16'hDEAD);
    check("R3 pointer advanced", mem_addr, 8);
  endtask

  task automatic t_hold();
    int k;
    bit pat [10] = '{1,0,0,1,1,0,1,0,0,1};
    fill(16'hBEEF);
    field_start();
    k = 0;
    for (int s = 0; s < 10; s++) begin
      wr_en = pat[s]; in_en = 1; din = 16'(16'h0300 + s);
      tick();
    end
    drain();
    for (int s = 0; s < 10; s++)
      if (pat[s]) begin
        check("R2 stored word", ram[k], 16'h0300 + s);
        k++;
      end
    check("R2 hold addr", mem_addr, 5);
    check("R2 nothing past", ram[5], 16'hBEEF);
  endtask

  task automatic t_wrap();
    fill(16'h0000);
    field_start();
    for (int i = 0; i < 20; i++) begin
      wr_en = 1; in_en = 1; din = 16'(16'h0100 + i);
      tick();
    end
    drain();
    check("R5 addr after wrap", mem_addr, 4);
    for (int i = 0; i < 4; i++) check("R5 overwritten", ram[i], 16'h0110 + i);
    check("R5 untouched", ram[5], 16'h0105);
  endtask

  task automatic t_priority();
    fill(16'h7777);
    field_start();
    wr_en = 1; in_en = 1; din = 16'h1111;
    tick();
    din = 16'h2222;
    tick();
    wr_rst = 1; din = 16'h3333;
    tick();
    wr_rst = 0; wr_en = 0;
    check("R6 no strobe after reset", mem_we, 0);
    repeat (3) tick();
    check("R6 ram[0]", ram[0], 16'h7777);
    check("R6 ram[1]", ram[1], 16'h7777);
    check("R1 addr", mem_addr, 0);
    check("R7 early reset flagged", proto_err, 1);
    field_start();
    check("R7 cleared", proto_err, 0);
    wr_en = 1; in_en = 1;
    tick();
    wr_en = 0;
    repeat (2) tick();
    wr_rst = 1;
    tick();
    wr_rst = 0;
    check("R7 two idle edges", proto_err, 1);
    repeat (4) tick();
    check("R7 held", proto_err, 1);
  endtask

  initial begin
    #1;
    t_reset_state();
    #20;
    @(negedge clk);
    rst_n = 1;
    tick();
    t_latency();
    t_mask();
    t_hold();
    t_wrap();
    t_priority();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end
endmodule